// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller. It serves three banks of 32 pins each, numbered 0 to 95, where a pin's bank is its number divided by 32. Software sets each pin's direction and changes output levels only through atomic set and clear writes, so two agents touching different pins never disturb each other. Software can also read the synchronized pin levels and arm interrupts on rising edges, falling edges or both.

Pad inputs pass through a two-flop synchronizer. A per-bank polarity mask is then applied. Edges are found by comparing the polarity-adjusted level with the previous sample. An enabled edge latches a bit in a write-one-to-clear status register. One interrupt line is high while any status bit in any bank is set.

The bus uses word addresses. The upper three bits of `busWordAddr` select the register function and the lower two bits select the bank, so the byte offset is function*0x10 + bank*0x4. Writes take effect at the clock edge. Reads are combinational from the current address.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: The word address is {function[2:0], bank[1:0]}. The function codes are: 0 direction, 1 polarity, 2 level, 3 set, 4 clear, 5 rise enable, 6 fall enable, 7 status. A write reaches exactly one register of one bank.
- R2: The direction register is read/write. A 1 in bit n makes pin n of that bank an output, so `padOe` for that pin is 1. A 0 makes it an input.
- R3: Writing to the set register drives high every pin whose data bit is 1 and leaves pins with a 0 bit unchanged. The set register reads as 0.
- R4: Writing to the clear register drives low every pin whose data bit is 1 and leaves pins with a 0 bit unchanged. The clear register reads as 0.
- R5: Reading the level register returns the pad input XOR polarity. A pad change becomes visible in this register after two clock edges.
- R6: The polarity register is read/write. A 1 bit inverts that pin's sensed level for the level register and for edge detection. A 0 bit leaves the level uninverted.
- R7: When a pin's rise enable bit is 1, a 0-to-1 transition of its sensed level sets its status bit on the third clock edge after the pad changes.
- R8: When a pin's fall enable bit is 1, a 1-to-0 transition of its sensed level sets its status bit. With both enables set, either transition sets it.
- R9: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged. A status bit never clears in any other way.
- R10: If an enabled edge and a write of 1 to the same status bit happen in the same cycle, the bit stays set.
- R11: `irq` is 1 exactly when any status bit of any bank is 1.
- R12: After reset, every register is 0. All pins are inputs, `padOut` is 0 and `irq` is 0.
- R13: Bank slot 3 is unmapped. Reads from it return 0 and writes to it change nothing.
- R14: Changing the polarity register never creates an edge by itself, so no status bit is set by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWordAddr | input | 5 | Word address {function, bank} |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busWordAddr |
| padIn | input | 96 | Raw pad levels, bank b at bits [32b+31:32b] |
| padOut | output | 96 | Output levels driven to the pads |
| padOe | output | 96 | Output enables, equal to the direction registers |
| irq | output | 1 | Combined interrupt from all banks |

## Verification
The embedded properties check the following on every cycle:
- no write reaches more than one register;
- a status bit only drops where a one was written;
- a status bit only rises where an edge enable was on;
- an edge always beats a simultaneous clear;
- output levels move only on set or clear writes, in the direction written.

Other behaviour can only be shown by the bench's scenarios, which compare against a register model:
- the exact two- and three-edge latencies from pad to level and to status;
- the polarity change that must not produce an edge;
- the unmapped bank slot;
- the combined interrupt across banks under random mixes of register writes and pad toggles.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  localparam int FUNC_W  = 3;
  localparam int SLOT_W  = 2;
  localparam int WADDR_W = FUNC_W + SLOT_W;

  typedef enum logic [FUNC_W-1:0] {
    FN_DIR   = 3'd0,
    FN_POL   = 3'd1,
    FN_LEVEL = 3'd2,
    FN_SET   = 3'd3,
    FN_CLR   = 3'd4,
    FN_RISE  = 3'd5,
    FN_FALL  = 3'd6,
    FN_STAT  = 3'd7
  } gpioFunc_e;

  typedef struct packed {
    logic dirWr;
    logic polWr;
    logic setWr;
    logic clrWr;
    logic riseWr;
    logic fallWr;
    logic statWr;
  } bankStrobe_t;
endpackage

// File: rtl/gpio_reg_decode.sv
`timescale 1ns/1ps
module gpio_reg_decode
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [WADDR_W-1:0]                busWordAddr,
  input  logic                              busWrEn,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]  bankRd,
  output bankStrobe_t [NUM_BANKS-1:0]       bankStb,
  output gpioFunc_e                         rdFunc,
  output logic [BANK_W-1:0]                 busRdData
);
  logic [SLOT_W-1:0] slotSel;
  gpioFunc_e         funcSel;

  assign slotSel = busWordAddr[SLOT_W-1:0];
  assign funcSel = gpioFunc_e'(busWordAddr[WADDR_W-1:SLOT_W]);
  assign rdFunc  = funcSel;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_stb
    logic hitWr;
    assign hitWr = busWrEn && (slotSel == SLOT_W'(b));
    assign bankStb[b].dirWr  = hitWr && (funcSel == FN_DIR);
    assign bankStb[b].polWr  = hitWr && (funcSel == FN_POL);
    assign bankStb[b].setWr  = hitWr && (funcSel == FN_SET);
    assign bankStb[b].clrWr  = hitWr && (funcSel == FN_CLR);
    assign bankStb[b].riseWr = hitWr && (funcSel == FN_RISE);
    assign bankStb[b].fallWr = hitWr && (funcSel == FN_FALL);
    assign bankStb[b].statWr = hitWr && (funcSel == FN_STAT);
  end

  always_comb begin
    busRdData = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (slotSel == SLOT_W'(b)) busRdData = busRdData | bankRd[b];
    end
  end

  // R1: a single write reaches at most one register
  p_single_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bankStb));

  // R13: unmapped slot reads zero
  p_unmapped_zero_r13: assert property (@(posedge clk) disable iff (!rstN)
    (int'(slotSel) >= NUM_BANKS) |-> (busRdData == '0));
endmodule

// File: rtl/gpio_bank_dp.sv
`timescale 1ns/1ps
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       stb,
  input  logic [BANK_W-1:0] wrData,
  input  gpioFunc_e         rdFunc,
  input  logic [BANK_W-1:0] padIn,
  output logic [BANK_W-1:0] padOut,
  output logic [BANK_W-1:0] padOe,
  output logic [BANK_W-1:0] rdWord,
  output logic              anyPend
);
  logic [BANK_W-1:0] dirQ, polQ, outQ, riseQ, fallQ, statQ;
  logic [BANK_W-1:0] syncA, syncB, prevRaw;
  logic [BANK_W-1:0] curLvl, prevLvl, edgeHit, clrMask;

  // synchronizer and previous raw sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      prevRaw <= '0;
    end else begin
      syncA   <= padIn;
      syncB   <= syncA;
      prevRaw <= syncB;
    end
  end

  // both samples see the current polarity, so a polarity write makes no edge
  assign curLvl  = syncB ^ polQ;
  assign prevLvl = prevRaw ^ polQ;
  assign edgeHit = (riseQ & curLvl & ~prevLvl) | (fallQ & ~curLvl & prevLvl);
  assign clrMask = stb.statWr ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ  <= '0;
      polQ  <= '0;
      outQ  <= '0;
      riseQ <= '0;
      fallQ <= '0;
      statQ <= '0;
    end else begin
      if (stb.dirWr)  dirQ  <= wrData;
      if (stb.polWr)  polQ  <= wrData;
      if (stb.riseWr) riseQ <= wrData;
      if (stb.fallWr) fallQ <= wrData;
      if (stb.setWr)      outQ <= outQ | wrData;
      else if (stb.clrWr) outQ <= outQ & ~wrData;
      statQ <= (statQ & ~clrMask) | edgeHit;
    end
  end

  always_comb begin
    unique case (rdFunc)
      FN_DIR:   rdWord = dirQ;
      FN_POL:   rdWord = polQ;
      FN_LEVEL: rdWord = curLvl;
      FN_RISE:  rdWord = riseQ;
      FN_FALL:  rdWord = fallQ;
      FN_STAT:  rdWord = statQ;
      default:  rdWord = '0;
    endcase
  end

  assign padOut  = outQ;
  assign padOe   = dirQ;
  assign anyPend = |statQ;

  // R9: a status bit drops only where a one was written
  p_stat_drop_w1c_r9: assert property (@(posedge clk) disable iff (!rstN)
    (($past(statQ) & ~statQ & ~$past(clrMask)) == '0));

  // R7 / R8: a status bit rises only where an edge enable was on
  p_stat_rise_enabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((statQ & ~$past(statQ) & ~($past(riseQ) | $past(fallQ))) == '0));

  // R10: an edge wins against a simultaneous clear
  p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(edgeHit) != '0) |-> ((statQ & $past(edgeHit)) == $past(edgeHit)));

  // R3 / R4: outputs move only on set or clear writes
  p_out_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(stb.setWr) && !$past(stb.clrWr)) |-> $stable(outQ));

  p_set_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.setWr) |-> ((outQ & $past(wrData)) == $past(wrData)));

  p_clear_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.clrWr) |-> ((outQ & $past(wrData)) == '0));
endmodule

// File: rtl/gpio_banked_ctrl.sv
`timescale 1ns/1ps
module gpio_banked_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  localparam int PINS     = NUM_BANKS * BANK_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WADDR_W-1:0] busWordAddr,
  input  logic               busWrEn,
  input  logic [BANK_W-1:0]  busWrData,
  output logic [BANK_W-1:0]  busRdData,
  input  logic [PINS-1:0]    padIn,
  output logic [PINS-1:0]    padOut,
  output logic [PINS-1:0]    padOe,
  output logic               irq
);
  bankStrobe_t [NUM_BANKS-1:0]      bankStb;
  logic [NUM_BANKS-1:0][BANK_W-1:0] bankRd;
  logic [NUM_BANKS-1:0]             bankPend;
  gpioFunc_e                        rdFunc;

  gpio_reg_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_decode (
    .clk(clk), .rstN(rstN), .busWordAddr(busWordAddr), .busWrEn(busWrEn),
    .bankRd(bankRd), .bankStb(bankStb), .rdFunc(rdFunc), .busRdData(busRdData)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank_dp #(.BANK_W(BANK_W)) u_bank (
      .clk(clk), .rstN(rstN), .stb(bankStb[b]), .wrData(busWrData),
      .rdFunc(rdFunc), .padIn(padIn[b*BANK_W +: BANK_W]),
      .padOut(padOut[b*BANK_W +: BANK_W]), .padOe(padOe[b*BANK_W +: BANK_W]),
      .rdWord(bankRd[b]), .anyPend(bankPend[b])
    );
  end

  assign irq = |bankPend;
endmodule

// File: tb/gpio_banked_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_banked_ctrl_tb;
  localparam int NB = 3;
  localparam int W  = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [4:0]    busWordAddr = '0;
  logic          busWrEn = 1'b0;
  logic [W-1:0]  busWrData = '0;
  logic [W-1:0]  busRdData;
  logic [NB*W-1:0] padIn = '0;
  logic [NB*W-1:0] padOut, padOe;
  logic          irq;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] dirM[NB], polM[NB], outM[NB], riseM[NB], fallM[NB], statM[NB], padM[NB];

  always #2.5 clk = ~clk;

  gpio_banked_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busWordAddr(busWordAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .irq(irq)
  );

  function automatic logic [4:0] wa(int fn, int bank);
    return {fn[2:0], bank[1:0]};
  endfunction

  function automatic logic [W-1:0] expRead(int fn, int bank);
    if (bank >= NB) return '0;
    case (fn)
      0: return dirM[bank];
      1: return polM[bank];
      2: return padM[bank] ^ polM[bank];
      5: return riseM[bank];
      6: return fallM[bank];
      7: return statM[bank];
      default: return '0;
    endcase
  endfunction

  task automatic chk(string req, logic [NB*W-1:0] act, logic [NB*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int fn, int bank, logic [W-1:0] d);
    busWordAddr = wa(fn, bank);
    busWrData = d;
    busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    busWrData = '0;
    if (bank < NB) begin
      case (fn)
        0: dirM[bank] = d;
        1: polM[bank] = d;
        3: outM[bank] = outM[bank] | d;
        4: outM[bank] = outM[bank] & ~d;
        5: riseM[bank] = d;
        6: fallM[bank] = d;
        7: statM[bank] = statM[bank] & ~d;
        default: ;
      endcase
    end
  endtask

  task automatic rdChk(string req, int fn, int bank);
    busWordAddr = wa(fn, bank);
    #1;
    chk(req, {{(NB-1)*W{1'b0}}, busRdData}, {{(NB-1)*W{1'b0}}, expRead(fn, bank)});
  endtask

  task automatic applyEdges(int bank, logic [W-1:0] val);
    logic [W-1:0] pOld, pNew;
    pOld = padM[bank] ^ polM[bank];
    pNew = val ^ polM[bank];
    statM[bank] = statM[bank] | (riseM[bank] & ~pOld & pNew) | (fallM[bank] & pOld & ~pNew);
    padM[bank] = val;
    padIn[bank*W +: W] = val;
  endtask

  task automatic setPad(int bank, logic [W-1:0] val);
    applyEdges(bank, val);
    repeat (3) @(negedge clk);
  endtask

  task automatic checkAll(string req);
    logic [NB*W-1:0] o, e;
    logic anyS;
    for (int b = 0; b < NB; b++) begin
      for (int f = 0; f < 8; f++) rdChk(req, f, b);
    end
    rdChk({req, "/R13"}, 0, 3);
    anyS = 1'b0;
    for (int b = 0; b < NB; b++) begin
      o[b*W +: W] = outM[b];
      e[b*W +: W] = dirM[b];
      anyS = anyS | (|statM[b]);
    end
    chk({req, "/R3 padOut"}, padOut, o);
    chk({req, "/R2 padOe"}, padOe, e);
    chk({req, "/R11 irq"}, {{(NB*W-1){1'b0}}, irq}, {{(NB*W-1){1'b0}}, anyS});
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int b = 0; b < NB; b++) begin
      dirM[b] = '0; polM[b] = '0; outM[b] = '0; riseM[b] = '0;
      fallM[b] = '0; statM[b] = '0; padM[b] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12: reset state
    checkAll("R12");

    // R1, R2: direction per bank
    wr(0, 1, 32'hF0F0_0001);
    checkAll("R2");

    // R3, R4: set/clear with zero bits untouched
    wr(3, 0, 32'h0000_00FF);
    wr(3, 2, 32'h8000_0001);
    wr(4, 0, 32'h0000_000F);
    checkAll("R3");
    wr(4, 2, 32'h0000_0000);
    checkAll("R4");

    // R5: two-edge latency of level read
    applyEdges(0, 32'h1234_5678);
    @(negedge clk);
    busWordAddr = wa(2, 0); #1;
    chk("R5 before", {64'd0, busRdData}, 96'd0);
    @(negedge clk);
    busWordAddr = wa(2, 0); #1;
    chk("R5 after", {64'd0, busRdData}, {64'd0, 32'h1234_5678});
    @(negedge clk);

    // R6, R14: polarity inverts level, no edge from a polarity write
    wr(5, 0, 32'hFFFF_FFFF);
    wr(6, 0, 32'hFFFF_FFFF);
    wr(1, 0, 32'h00FF_00FF);
    repeat (3) @(negedge clk);
    checkAll("R14");

    // R7, R11: rising edge on bank 2 bit 5
    wr(5, 2, 32'h0000_0020);
    setPad(2, 32'h0000_0020);
    checkAll("R7");

    // R8: falling and both edges
    wr(6, 1, 32'h0000_0003);
    wr(5, 1, 32'h0000_0002);
    setPad(1, 32'h0000_0003);
    setPad(1, 32'h0000_0000);
    checkAll("R8");

    // R9: writing zeros leaves status, ones clear
    wr(7, 1, 32'h0000_0000);
    checkAll("R9 zero");
    wr(7, 1, 32'h0000_0001);
    checkAll("R9 one");

    // R10: edge and clear in the same cycle on bank 2 bit 5
    setPad(2, 32'h0000_0000);
    applyEdges(2, 32'h0000_0020);
    @(negedge clk);
    @(negedge clk);
    wr(7, 2, 32'h0000_0020);
    statM[2] = statM[2] | 32'h0000_0020;
    @(negedge clk);
    checkAll("R10");
    wr(7, 2, 32'hFFFF_FFFF);
    wr(7, 1, 32'hFFFF_FFFF);
    wr(7, 0, 32'hFFFF_FFFF);
    checkAll("R9 all");

    // R13: writes to the unmapped slot change nothing
    for (int f = 0; f < 8; f++) wr(f, 3, 32'hFFFF_FFFF);
    checkAll("R13");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op, bank, fn;
      op = $urandom_range(0, 9);
      bank = $urandom_range(0, NB);
      if (op < 6) begin
        fn = $urandom_range(0, 7);
        wr(fn, bank, $urandom());
        repeat (2) @(negedge clk);
      end else if (bank < NB) begin
        setPad(bank, $urandom() & $urandom());
      end
      if (it % 4 == 0) checkAll("R1 random");
    end
    checkAll("R11 final");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule